// File: doc/BRIEF.md
# Serial Latched Register Receiver

This block is the device-side end of a three-wire configuration port made of a serial clock, a serial data line and a latch-enable line. While latch-enable is low, the controller shifts in a 32-bit word, most significant bit first, one bit on each rising serial clock edge. When latch-enable goes high, the block splits the word into a 4-bit address (the low four bits) and a 28-bit data field (the upper 28 bits). It then writes the data field into the matching entry of a 16-entry register bank. Every register drives its own slice of one parallel output bus.

The three serial lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock.

A word that arrives with any bit count other than 32 is dropped without touching the bank. Two register writes have side effects:
- Register 0 carries a self-clearing reset bit. Setting it clears every other register.
- Every write to register 15 raises a one-cycle calibration-start pulse. Software rewrites register 15 whenever a setting that calibration depends on changes.

Top module: `cfg_serial_rx`

## Requirements
- R1: A 32-bit word is shifted in MSB first, one bit per rising edge of `ser_clk_i`. Word bits [3:0] select the register, and word bits [31:4] become that register's 28-bit value (word bit 4 lands in register bit 0).
- R2: Rising edges of `ser_clk_i` that occur while `ser_le_i` is high shift nothing and do not count toward the word length.
- R3: The addressed register shows its new value on `reg_bank_o` no more than 10 system clock cycles after `ser_le_i` rises.
- R4: If `ser_le_i` rises after any number of serial clock edges other than 32 (0, 1, 31, 33 ...), no register changes and no calibration pulse is produced.
- R5: A valid write to register 0 with data bit 13 set (word bit 17) clears registers 1 to 15 to zero. Register 0 takes the written value with bit 13 cleared, so register 0 bit 13 always reads 0.
- R6: Every valid write to register 15 produces exactly one `cal_start_o` pulse, one system clock wide. Writes to any other register produce none.
- R7: Repeated writes to register 15 each produce their own pulse.
- R8: While `rst_n` is low at a system clock edge, all registers are cleared to zero and `cal_start_o` is 0.
- R9: Register i occupies bits [28*i+27 : 28*i] of `reg_bank_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, sampled on rising serial clock |
| ser_le_i | input | 1 | Latch enable: low while shifting, rising edge commits |
| reg_bank_o | output | 448 | All 16 registers of 28 bits, register i at bits [28*i +: 28] |
| cal_start_o | output | 1 | One-cycle calibration-start pulse on a register 15 write |

## Verification
The assertions take several things for granted about the serial inputs:
- Each serial line holds each level for at least two system clock cycles.
- The data line is stable around a serial clock rise.
- Latch-enable does not rise in the same synchronized cycle as a serial clock rise.

Only under these conditions is a committed word equal to the bits that were driven. The stimulus holds every serial level for four system clocks, which keeps the serial clock eight times slower than the system clock. It changes data only while the serial clock is low. It raises latch-enable four cycles after the last serial clock fall, and keeps the serial clock low while latch-enable rises.

// File: rtl/cfgrx_pkg.sv
// Shared constants for the serial latched register receiver.
// Assumes nothing; holds only default geometry and bit positions.
package cfgrx_pkg;
    localparam int unsigned CFGRX_WORD_W      = 32;
    localparam int unsigned CFGRX_ADDR_W      = 4;
    localparam int unsigned CFGRX_NUM_REGS    = 16;
    localparam int unsigned CFGRX_SYNC_STAGES = 2;
    localparam int unsigned CFGRX_RST_BIT     = 13;
    localparam int unsigned CFGRX_CAL_REG     = 15;
    // Positions of the serial lines in the synchronizer vector
    localparam int unsigned LINE_CLK = 0;
    localparam int unsigned LINE_DAT = 1;
    localparam int unsigned LINE_LE  = 2;
    localparam int unsigned NUM_LINES = 3;
endpackage

// File: rtl/cfgrx_sync.sv
// Multi-bit level synchronizer: each bit passes through its own chain of
// STAGES flops. Assumes the bits are independent and each level is held
// long enough (at least STAGES system cycles) to be seen.
module cfgrx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/cfgrx_edge.sv
// Rising-edge detector on a signal already in the system clock domain.
// The output is high for one cycle when the input goes from 0 to 1.
module cfgrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;
    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end
    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/cfgrx_shift.sv
// Serial word assembler. Shifts one synchronized data bit in, MSB first, on
// each serial clock rise while latch-enable is low, and counts the bits.
// On a latch-enable rise it emits a one-cycle write strobe if exactly
// WORD_W bits arrived, then clears the count. Assumes a latch-enable rise
// and a serial clock rise never fall in the same system cycle.
module cfgrx_shift #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              dat_i,
    input  logic              le_lvl_i,
    input  logic              le_rise_i,
    output logic              wr_vld_o,
    output logic [WORD_W-1:0] wr_word_o
);
    localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              vld_q;

    // Shift register, saturating bit counter and commit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (le_rise_i) begin
                vld_q <= (cnt_q == CNT_FULL);
                cnt_q <= '0;
            end else if (sclk_rise_i && !le_lvl_i) begin
                shreg_q <= {shreg_q[WORD_W-2:0], dat_i};
                if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wr_vld_o  = vld_q;
    assign wr_word_o = shreg_q;
endmodule

// File: rtl/cfgrx_bank.sv
// Register bank. On a write strobe the addressed register takes the data.
// Register 0 carries a self-clearing reset bit that clears every other
// register. A write to register CAL_REG produces a one-cycle calibration
// pulse. Addresses at or above NUM_REGS are ignored.
module cfgrx_bank #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 28,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned RST_BIT  = 13,
    parameter int unsigned CAL_REG  = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_vld_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [NUM_REGS*DATA_W-1:0] bank_o,
    output logic                       cal_start_o
);
    localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;

    logic bank_rst;
    logic cal_q;

    // A reset request is a valid write to register 0 with the reset bit set
    assign bank_rst = wr_vld_i && (wr_addr_i == '0) && wr_data_i[RST_BIT];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        logic              hit;
        assign hit = wr_vld_i && (wr_addr_i == ADDR_W'(r));
        if (r == 0) begin : g_ctl
            // Register 0: store the value with the reset bit self-cleared
            always_ff @(posedge clk) begin
                if (!rst_n)   val_q <= '0;
                else if (hit) val_q <= wr_data_i & ~RST_MASK;
            end
        end else begin : g_plain
            // Other registers: write on hit, clear on a bank reset request
            always_ff @(posedge clk) begin
                if (!rst_n)         val_q <= '0;
                else if (hit)       val_q <= wr_data_i;
                else if (bank_rst)  val_q <= '0;
            end
        end
        assign bank_o[r*DATA_W +: DATA_W] = val_q;
    end

    // One-cycle calibration start on every write to the calibration register
    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= 1'b0;
        else        cal_q <= wr_vld_i && (wr_addr_i == ADDR_W'(CAL_REG));
    end
    assign cal_start_o = cal_q;
endmodule

// File: rtl/cfg_serial_rx.sv
// Serial latched register receiver top. Synchronizes the three serial lines
// into the system clock, detects serial clock and latch-enable rises,
// assembles words and writes them into the register bank. Assumes the system
// clock is at least 4x the serial clock and each serial level lasts at least
// two system cycles.
module cfg_serial_rx
    import cfgrx_pkg::*;
#(
    parameter int unsigned WORD_W      = CFGRX_WORD_W,
    parameter int unsigned ADDR_W      = CFGRX_ADDR_W,
    parameter int unsigned NUM_REGS    = CFGRX_NUM_REGS,
    parameter int unsigned SYNC_STAGES = CFGRX_SYNC_STAGES,
    parameter int unsigned RST_BIT     = CFGRX_RST_BIT,
    parameter int unsigned CAL_REG     = CFGRX_CAL_REG,
    localparam int unsigned DATA_W     = WORD_W - ADDR_W,
    localparam int unsigned BANK_W     = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_le_i,
    output logic [BANK_W-1:0] reg_bank_o,
    output logic              cal_start_o
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    logic                 sclk_rise;
    logic                 le_rise;
    logic                 wr_vld;
    logic [WORD_W-1:0]    wr_word;
    logic [ADDR_W-1:0]    wr_addr;
    logic [DATA_W-1:0]    wr_data;

    // Gather the serial lines into one vector for the synchronizer
    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_CLK] = ser_clk_i;
        raw_lines[LINE_DAT] = ser_dat_i;
        raw_lines[LINE_LE]  = ser_le_i;
    end

    cfgrx_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_lines), .q_o(sync_lines)
    );

    cfgrx_edge u_clk_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sync_lines[LINE_CLK]), .rise_o(sclk_rise)
    );

    cfgrx_edge u_le_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sync_lines[LINE_LE]), .rise_o(le_rise)
    );

    cfgrx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise_i(sclk_rise), .dat_i(sync_lines[LINE_DAT]),
        .le_lvl_i(sync_lines[LINE_LE]), .le_rise_i(le_rise),
        .wr_vld_o(wr_vld), .wr_word_o(wr_word)
    );

    // Address in the trailing bits, data field above it
    assign wr_addr = wr_word[ADDR_W-1:0];
    assign wr_data = wr_word[WORD_W-1:ADDR_W];

    cfgrx_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .RST_BIT(RST_BIT), .CAL_REG(CAL_REG)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_vld_i(wr_vld), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .bank_o(reg_bank_o), .cal_start_o(cal_start_o)
    );
endmodule

// File: rtl/cfgrx_chk.sv
// Assertion checker for cfg_serial_rx, bound to the top module. It observes
// the internal write strobe and the bank outputs.
module cfgrx_chk #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 28,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned RST_BIT  = 13,
    parameter int unsigned CAL_REG  = 15
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_vld,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [NUM_REGS*DATA_W-1:0] bank,
    input logic                       cal_start
);
    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> $stable(bank));

    // R5
    bank_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wr_addr == '0 && wr_data[RST_BIT]) |=> (bank[NUM_REGS*DATA_W-1:DATA_W] == '0));

    // R5
    rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank[RST_BIT] == 1'b0);

    // R6
    cal_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R6
    cal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> ($past(wr_vld) && $past(wr_addr) == ADDR_W'(CAL_REG)));

    // R6
    cal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wr_addr == ADDR_W'(CAL_REG)) |=> cal_start);

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_wr
        // R1
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld && wr_addr == ADDR_W'(r)) |=> (bank[r*DATA_W +: DATA_W] == $past(wr_data)));
    end
endmodule

bind cfg_serial_rx cfgrx_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .RST_BIT(RST_BIT), .CAL_REG(CAL_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank(reg_bank_o), .cal_start(cal_start_o)
);

// File: tb/sim_cfg_serial_rx.sv
// Self-checking bench: sweeps every register address with computed data,
// then malformed words, clocks under a high latch-enable, the bank reset
// bit and repeated calibration writes.
module sim_cfg_serial_rx;
    localparam int NREG = 16;
    localparam int DW   = 28;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ser_clk = 1'b0;
    logic            ser_dat = 1'b0;
    logic            ser_le = 1'b1;
    logic [NREG*DW-1:0] bank;
    logic            cal;

    int vectors = 0;
    int miscompares = 0;
    int cal_cnt = 0;
    int cal_wide = 0;
    logic cal_prev = 1'b0;
    logic [DW-1:0] exp_reg [NREG];
    int exp_cal = 0;

    always #4 clk = ~clk;

    cfg_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_le_i(ser_le), .reg_bank_o(bank), .cal_start_o(cal)
    );

    // Count calibration pulses and pulses longer than one cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (cal) cal_cnt++;
            if (cal && cal_prev) cal_wide++;
        end
        cal_prev <= cal;
    end

    function automatic logic [DW-1:0] pat(input int a, input int k);
        logic [31:0] v;
        v = (32'(a) * 32'h0135_79BD) ^ (32'(k) * 32'h00F0_F0F1) ^ 32'h00A5_C3E1;
        return v[DW-1:0];
    endfunction

    task automatic send_word(input logic [31:0] w, input int nbits);
        @(negedge clk); ser_le = 1'b0; repeat (4) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = (i < 32) ? w[i[4:0]] : 1'b0;
            repeat (4) @(negedge clk); ser_clk = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk); ser_le = 1'b1;
        repeat (10) @(negedge clk); ser_dat = 1'b0;
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++) begin
            vectors++;
            if (bank[i*DW +: DW] !== exp_reg[i]) begin
                miscompares++;
                $display("FAIL %s reg %0d: actual %h expected %h", tag, i, bank[i*DW +: DW], exp_reg[i]);
            end
        end
    endtask

    task automatic check_cal(input string tag);
        vectors++;
        if (cal_cnt != exp_cal || cal_wide != 0) begin
            miscompares++;
            $display("FAIL %s cal pulses: actual %0d (wide %0d) expected %0d (wide 0)", tag, cal_cnt, cal_wide, exp_cal);
        end
    endtask

    task automatic write_reg(input int a, input logic [DW-1:0] d);
        send_word({d, 4'(a)}, 32);
        if (a == 0 && d[13]) begin
            for (int i = 1; i < NREG; i++) exp_reg[i] = '0;
        end
        exp_reg[a] = (a == 0) ? (d & ~(DW'(1) << 13)) : d;
        if (a == 15) exp_cal++;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_reg[i] = '0;
        repeat (5) @(negedge clk);
        // R8: reset state
        check_bank("R8");
        vectors++;
        if (cal !== 1'b0) begin
            miscompares++;
            $display("FAIL R8 cal_start: actual %b expected 0", cal);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1/R3/R9: sweep every address, two data patterns, descending order
        for (int k = 0; k < 2; k++) begin
            for (int a = NREG - 1; a >= 0; a--) begin
                logic [DW-1:0] d;
                d = pat(a, k);
                if (a == 0) d[13] = 1'b0;
                write_reg(a, d);
                check_bank("R1/R3/R9");
                check_cal("R6");
            end
        end

        // R7: repeated calibration writes, each pulses once
        for (int n = 0; n < 3; n++) begin
            write_reg(15, pat(15, n + 7));
            check_cal("R7");
        end
        check_bank("R7");

        // R4: wrong bit counts are dropped, even when aimed at register 15
        send_word({pat(15, 9), 4'd15}, 31);
        check_bank("R4 31 bits"); check_cal("R4");
        send_word({pat(3, 9), 4'd3}, 33);
        check_bank("R4 33 bits"); check_cal("R4");
        send_word({pat(5, 9), 4'd5}, 1);
        check_bank("R4 1 bit");
        send_word(32'h0, 0);
        check_bank("R4 0 bits"); check_cal("R4");

        // R2: serial clocks under a high latch-enable are ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ser_dat = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (10) @(negedge clk); ser_dat = 1'b0;
        check_bank("R2 idle clocks");
        write_reg(5, pat(5, 11));
        check_bank("R2 following word");

        // R5: reset bit in register 0 clears the rest of the bank
        write_reg(0, pat(0, 3) | (DW'(1) << 13));
        check_bank("R5");
        check_cal("R5");
        write_reg(9, pat(9, 4));
        check_bank("R5 after");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule